// File: doc/BRIEF.md
# Two-Level Address Translation Buffer

This block translates virtual page numbers to physical page numbers for a processor core that has separate instruction-fetch and data-access ports. Each port has its own tiny micro-buffer of recently used translations. When the micro-buffer holds the page, the answer comes back in the same cycle as the request. When it does not, the block consults a shared main array of fully associative entries. That costs one extra cycle, and the hardware then copies the translation into the micro-buffer of the port that asked.

Software alone fills the main array, through a write port that addresses one entry by index. Each main entry covers two adjacent virtual pages: an even page and the odd page after it. Each of the two pages has its own physical page number, valid bit and writable bit.

A lookup that finds nothing raises a refill fault so that software can install the entry and restart the access. A store to a read-only page raises a modify fault. A lookup that matches more than one main entry raises a multiple-match error. The requester holds its request and page number steady until it sees a result, and it drops the request after a fault.

Top module: `xlat_two_level`

## Requirements
- R1: The main array holds MAIN_N (default 16) entries, written by index through the write port. Each entry has a pair tag (virtual page number without bit 0), two physical page numbers, a two-bit valid field and a two-bit writable field. Index [0] of each pair field is the even page (virtual page bit 0 = 0) and index [1] is the odd page.
- R2: A request whose page is present in its port's micro-buffer raises ready in the same cycle and returns the physical page number.
- R3: A micro-buffer miss that hits exactly one main entry raises ready one cycle after the request and returns that entry's physical page number. The micro-buffer keeps the translation for later requests.
- R4: The instruction and data ports each have their own micro-buffer of MICRO_N (default 3) entries. These are filled only by hardware, so filling one side never makes the other side hit.
- R5: A micro-buffer miss for which no main entry has a matching tag with the addressed page valid raises that port's refill fault for one cycle, one cycle after the request, with no ready.
- R6: A data store that hits a page whose writable bit is 0 raises dt_modify_fault instead of ready.
- R7: A lookup that matches more than one main entry raises that port's multiple-match error one cycle after the request. Nothing is refilled.
- R8: Any write to the main array empties both micro-buffers, so the next request on either port takes the miss path.
- R9: When a micro-buffer is full, a refill replaces its least-recently-used entry. Both hits and refills count as uses.
- R10: When both ports miss in the same cycle, the data port is looked up first and the instruction port is looked up in the next cycle.
- R11: A lookup in the same cycle as a main-array write is discarded without refill or fault, and it is repeated in the next cycle.
- R12: Reset empties the main array and both micro-buffers, and holds every ready and fault output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_req | input | 1 | Instruction-fetch translation request |
| if_vpn | input | 20 | Instruction virtual page number |
| if_ready | output | 1 | Instruction translation valid |
| if_pfn | output | 20 | Instruction physical page number |
| if_refill_fault | output | 1 | Instruction main-array miss |
| if_multi_err | output | 1 | Instruction multiple main matches |
| dt_req | input | 1 | Data translation request |
| dt_vpn | input | 20 | Data virtual page number |
| dt_store | input | 1 | Data access is a store |
| dt_ready | output | 1 | Data translation valid |
| dt_pfn | output | 20 | Data physical page number |
| dt_refill_fault | output | 1 | Data main-array miss |
| dt_modify_fault | output | 1 | Store to a non-writable page |
| dt_multi_err | output | 1 | Data multiple main matches |
| wr_en | input | 1 | Main-array write strobe |
| wr_idx | input | 4 | Main entry index to write |
| wr_tag | input | 19 | Pair tag (virtual page number without bit 0) |
| wr_pfn_even | input | 20 | Physical page for the even virtual page |
| wr_pfn_odd | input | 20 | Physical page for the odd virtual page |
| wr_valid | input | 2 | Valid bits, [0] even, [1] odd |
| wr_writable | input | 2 | Writable bits, [0] even, [1] odd |

## Verification
Two functions can meet in one cycle: a software write to the main array, and a hardware refill of a micro-buffer after a miss. The bench provokes this by raising a data request for an absent page on the same clock edge as an unrelated write. It checks that the cycle after the request shows neither ready nor fault, and that ready with the correct physical page appears one cycle later than on a normal miss. A second collision, where both ports miss in the same cycle, is judged by the order and the cycle in which the two ready outputs rise.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  parameter int XL_VPN_W = 20;
  parameter int XL_PFN_W = 20;

  typedef logic [XL_VPN_W-1:0] vpn_t;
  typedef logic [XL_VPN_W-2:0] ptag_t;
  typedef logic [XL_PFN_W-1:0] pfn_t;

  // main entry: one tag covers an even/odd page pair
  typedef struct packed {
    ptag_t          tag;
    logic [1:0]     v;
    logic [1:0]     w;
    pfn_t [1:0]     pfn;
  } main_ent_t;

  // micro entry: a single page
  typedef struct packed {
    logic v;
    vpn_t vpn;
    pfn_t pfn;
    logic w;
  } micro_ent_t;

  function automatic ptag_t pair_tag(vpn_t vpn);
    return vpn[XL_VPN_W-1:1];
  endfunction

  function automatic logic page_half(vpn_t vpn);
    return vpn[0];
  endfunction
endpackage

// File: rtl/xlat_main_array.sv
module xlat_main_array import xlat_pkg::*; #(
  parameter int N = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [((N>1)?$clog2(N):1)-1:0] wr_idx,
  input  main_ent_t                     wr_ent,
  input  vpn_t                          lk_vpn,
  output logic                          lk_hit,
  output logic                          lk_multi,
  output pfn_t                          lk_pfn,
  output logic                          lk_w
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = $clog2(N + 1);

  logic [N-1:0] match_vec;
  pfn_t         gated_pfn [N];
  logic [N-1:0] gated_w;

  for (genvar g = 0; g < N; g++) begin : g_ent
    main_ent_t ent_q;
    logic      h;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ent_q <= '0;
      else if (wr_en && wr_idx == IW'(g))  ent_q <= wr_ent;
    end
    assign h            = page_half(lk_vpn);
    assign match_vec[g] = (ent_q.tag == pair_tag(lk_vpn)) && ent_q.v[h];
    assign gated_pfn[g] = match_vec[g] ? ent_q.pfn[h] : '0;
    assign gated_w[g]   = match_vec[g] & ent_q.w[h];
  end

  logic [CW-1:0] cnt;
  always_comb begin
    cnt    = '0;
    lk_pfn = '0;
    for (int i = 0; i < N; i++) begin
      cnt    = cnt + CW'(match_vec[i]);
      lk_pfn = lk_pfn | gated_pfn[i];
    end
    lk_w     = |gated_w;
    lk_hit   = (cnt == CW'(1));
    lk_multi = (cnt > CW'(1));
  end
endmodule

// File: rtl/xlat_micro.sv
module xlat_micro import xlat_pkg::*; #(
  parameter int N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic lk_en,
  input  vpn_t lk_vpn,
  output logic hit,
  output pfn_t hit_pfn,
  output logic hit_w,
  input  logic fill_en,
  input  vpn_t fill_vpn,
  input  pfn_t fill_pfn,
  input  logic fill_w
);
  localparam int AW = (N > 1) ? $clog2(N) : 1;

  micro_ent_t    ent_q [N];
  logic [AW-1:0] age_q [N];   // 0 = most recently used
  logic [N-1:0]  hv;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hv[g] = ent_q[g].v && (ent_q[g].vpn == lk_vpn);
  end

  logic [AW-1:0] hit_idx, victim, touch_idx;
  logic          found, touch_en;

  always_comb begin
    hit_idx = '0;
    hit_pfn = '0;
    hit_w   = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hv[i]) begin
        hit_idx = AW'(i);
        hit_pfn = ent_q[i].pfn;
        hit_w   = ent_q[i].w;
      end
    end
    hit = |hv;

    victim = '0;
    found  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!found && !ent_q[i].v) begin
        victim = AW'(i);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < N; i++) begin
        if (age_q[i] == AW'(N - 1)) victim = AW'(i);
      end
    end

    touch_en  = (lk_en && hit) || fill_en;
    touch_idx = fill_en ? victim : hit_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        ent_q[i] <= '0;
        age_q[i] <= AW'(i);
      end
    end else begin
      if (flush) begin
        for (int i = 0; i < N; i++) ent_q[i].v <= 1'b0;
      end else if (fill_en) begin
        ent_q[victim] <= '{v: 1'b1, vpn: fill_vpn, pfn: fill_pfn, w: fill_w};
      end
      if (touch_en && !flush) begin
        for (int i = 0; i < N; i++) begin
          if (AW'(i) == touch_idx)            age_q[i] <= '0;
          else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xlat_two_level.sv
module xlat_two_level import xlat_pkg::*; #(
  parameter int MAIN_N  = 16,
  parameter int MICRO_N = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   if_req,
  input  logic [XL_VPN_W-1:0]                    if_vpn,
  output logic                                   if_ready,
  output logic [XL_PFN_W-1:0]                    if_pfn,
  output logic                                   if_refill_fault,
  output logic                                   if_multi_err,
  input  logic                                   dt_req,
  input  logic [XL_VPN_W-1:0]                    dt_vpn,
  input  logic                                   dt_store,
  output logic                                   dt_ready,
  output logic [XL_PFN_W-1:0]                    dt_pfn,
  output logic                                   dt_refill_fault,
  output logic                                   dt_modify_fault,
  output logic                                   dt_multi_err,
  input  logic                                   wr_en,
  input  logic [((MAIN_N>1)?$clog2(MAIN_N):1)-1:0] wr_idx,
  input  logic [XL_VPN_W-2:0]                    wr_tag,
  input  logic [XL_PFN_W-1:0]                    wr_pfn_even,
  input  logic [XL_PFN_W-1:0]                    wr_pfn_odd,
  input  logic [1:0]                             wr_valid,
  input  logic [1:0]                             wr_writable
);
  // micro-buffer results
  logic i_hit, d_hit, i_hit_w, d_hit_w;
  pfn_t i_hit_pfn, d_hit_pfn;

  // main array port
  logic m_hit, m_multi, m_w;
  pfn_t m_pfn;
  vpn_t lk_vpn;

  // lookup arbitration and refill events (named for the checker)
  logic i_lookup, d_lookup, lk_live, i_fill, d_fill;
  logic i_rf_q, i_mm_q, d_rf_q, d_mm_q;
  logic i_pend, d_pend;

  main_ent_t wr_ent;
  assign wr_ent = '{tag: wr_tag, v: wr_valid, w: wr_writable,
                    pfn: {wr_pfn_odd, wr_pfn_even}};

  assign i_pend   = i_rf_q | i_mm_q;
  assign d_pend   = d_rf_q | d_mm_q;
  assign d_lookup = dt_req && !d_hit && !d_pend;
  assign i_lookup = if_req && !i_hit && !i_pend && !d_lookup;
  assign lk_vpn   = d_lookup ? dt_vpn : if_vpn;
  assign lk_live  = !wr_en;                  // a write cancels the lookup
  assign d_fill   = d_lookup && lk_live && m_hit;
  assign i_fill   = i_lookup && lk_live && m_hit;

  xlat_main_array #(.N(MAIN_N)) u_main (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_ent(wr_ent),
    .lk_vpn(lk_vpn), .lk_hit(m_hit), .lk_multi(m_multi),
    .lk_pfn(m_pfn), .lk_w(m_w)
  );

  xlat_micro #(.N(MICRO_N)) u_imicro (
    .clk(clk), .rst_n(rst_n), .flush(wr_en),
    .lk_en(if_req), .lk_vpn(if_vpn),
    .hit(i_hit), .hit_pfn(i_hit_pfn), .hit_w(i_hit_w),
    .fill_en(i_fill), .fill_vpn(lk_vpn), .fill_pfn(m_pfn), .fill_w(m_w)
  );

  xlat_micro #(.N(MICRO_N)) u_dmicro (
    .clk(clk), .rst_n(rst_n), .flush(wr_en),
    .lk_en(dt_req), .lk_vpn(dt_vpn),
    .hit(d_hit), .hit_pfn(d_hit_pfn), .hit_w(d_hit_w),
    .fill_en(d_fill), .fill_vpn(lk_vpn), .fill_pfn(m_pfn), .fill_w(m_w)
  );

  // fault pulses, one cycle after the lookup
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_rf_q <= 1'b0; i_mm_q <= 1'b0;
      d_rf_q <= 1'b0; d_mm_q <= 1'b0;
    end else begin
      i_rf_q <= i_lookup && lk_live && !m_hit && !m_multi;
      i_mm_q <= i_lookup && lk_live && m_multi;
      d_rf_q <= d_lookup && lk_live && !m_hit && !m_multi;
      d_mm_q <= d_lookup && lk_live && m_multi;
    end
  end

  // instruction-fetch response
  assign if_ready        = if_req && i_hit;
  assign if_pfn          = i_hit_pfn;
  assign if_refill_fault = i_rf_q;
  assign if_multi_err    = i_mm_q;

  // data-access response; i_hit_w is unused on the fetch side
  assign dt_modify_fault = dt_req && d_hit && dt_store && !d_hit_w;
  assign dt_ready        = dt_req && d_hit && !dt_modify_fault;
  assign dt_pfn          = d_hit_pfn;
  assign dt_refill_fault = d_rf_q;
  assign dt_multi_err    = d_mm_q;

  logic unused_ok;
  assign unused_ok = i_hit_w;
endmodule

// File: rtl/xlat_two_level_chk.sv
module xlat_two_level_chk (
  input logic clk,
  input logic rst_n,
  input logic i_lookup,
  input logic d_lookup,
  input logic i_hit,
  input logic d_hit,
  input logic wr_en,
  input logic if_refill_fault,
  input logic if_multi_err,
  input logic dt_refill_fault,
  input logic dt_multi_err,
  input logic dt_ready,
  input logic dt_store,
  input logic dt_modify_fault
);
  assert_one_lookup_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(i_lookup && d_lookup));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!i_hit && !d_hit));

  assert_ifault_after_lookup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    if_refill_fault |-> $past(i_lookup && !wr_en));

  assert_dfault_after_lookup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dt_refill_fault |-> $past(d_lookup && !wr_en));

  assert_multi_after_lookup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_multi_err || if_multi_err) |-> $past(i_lookup || d_lookup));

  assert_modify_blocks_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dt_modify_fault |-> (dt_store && !dt_ready));

  assert_fault_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dt_refill_fault |=> !dt_refill_fault);
endmodule

bind xlat_two_level xlat_two_level_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .i_lookup(i_lookup), .d_lookup(d_lookup),
  .i_hit(i_hit), .d_hit(d_hit), .wr_en(wr_en),
  .if_refill_fault(if_refill_fault), .if_multi_err(if_multi_err),
  .dt_refill_fault(dt_refill_fault), .dt_multi_err(dt_multi_err),
  .dt_ready(dt_ready), .dt_store(dt_store), .dt_modify_fault(dt_modify_fault)
);

// File: tb/xlat_two_level_tb.sv
`timescale 1ns/1ps
module xlat_two_level_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        if_req = 0, dt_req = 0, dt_store = 0, wr_en = 0;
  logic [19:0] if_vpn = '0, dt_vpn = '0, wr_pfn_even = '0, wr_pfn_odd = '0;
  logic [18:0] wr_tag = '0;
  logic [3:0]  wr_idx = '0;
  logic [1:0]  wr_valid = '0, wr_writable = '0;
  logic        if_ready, if_refill_fault, if_multi_err;
  logic        dt_ready, dt_refill_fault, dt_modify_fault, dt_multi_err;
  logic [19:0] if_pfn, dt_pfn;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  xlat_two_level u_dut (.*);

  // outcome codes: 0 ready, 1 refill fault, 2 modify fault, 3 multi match
  typedef struct packed {
    logic        side;   // 0 fetch, 1 data
    logic        st;
    logic [19:0] vpn;
    logic [1:0]  code;
    logic [19:0] pfn;
    logic [1:0]  lat;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 20'h20, 2'd0, 20'h100, 2'd1, 8'd3},   // R3 fetch miss, main hit
    '{1'b0, 1'b0, 20'h20, 2'd0, 20'h100, 2'd0, 8'd2},   // R2 fetch micro hit
    '{1'b1, 1'b0, 20'h20, 2'd0, 20'h100, 2'd1, 8'd4},   // R4 data side separate
    '{1'b1, 1'b1, 20'h21, 2'd2, 20'h000, 2'd1, 8'd6},   // R6 store to read-only odd page
    '{1'b1, 1'b0, 20'h21, 2'd0, 20'h101, 2'd0, 8'd2},   // R2 load same page hits
    '{1'b1, 1'b0, 20'h23, 2'd1, 20'h000, 2'd1, 8'd5},   // R5 odd half invalid
    '{1'b0, 1'b0, 20'h30, 2'd1, 20'h000, 2'd1, 8'd5},   // R5 no tag match
    '{1'b1, 1'b0, 20'h28, 2'd3, 20'h000, 2'd1, 8'd7},   // R7 two entries match
    '{1'b1, 1'b0, 20'h22, 2'd0, 20'h200, 2'd1, 8'd3},   // R3 third micro slot
    '{1'b1, 1'b0, 20'h20, 2'd0, 20'h100, 2'd0, 8'd9},   // R9 touch oldest
    '{1'b1, 1'b0, 20'h24, 2'd0, 20'h300, 2'd1, 8'd9},   // R9 evicts 0x21
    '{1'b1, 1'b0, 20'h20, 2'd0, 20'h100, 2'd0, 8'd9},   // R9 kept
    '{1'b1, 1'b0, 20'h22, 2'd0, 20'h200, 2'd0, 8'd9},   // R9 kept
    '{1'b1, 1'b0, 20'h21, 2'd0, 20'h101, 2'd1, 8'd9},   // R9 was evicted
    '{1'b1, 1'b1, 20'h25, 2'd0, 20'h301, 2'd1, 8'd1},   // R1 odd half writable
    '{1'b1, 1'b0, 20'h20, 2'd0, 20'h100, 2'd1, 8'd9},   // R9 evicted by 0x25
    '{1'b0, 1'b0, 20'h20, 2'd0, 20'h100, 2'd0, 8'd4}    // R4 fetch side untouched
  };

  task automatic check(input bit ok, input int req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic wr_entry(input logic [3:0] idx, input logic [18:0] tag,
                          input logic [19:0] pe, input logic [19:0] po,
                          input logic [1:0] v, input logic [1:0] w);
    @(negedge clk);
    wr_en = 1; wr_idx = idx; wr_tag = tag;
    wr_pfn_even = pe; wr_pfn_odd = po; wr_valid = v; wr_writable = w;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic access(input vec_t t);
    int   got_code, got_lat;
    logic [19:0] got_pfn;
    got_code = -1; got_lat = -1; got_pfn = '0;
    @(negedge clk);
    if (t.side) begin dt_req = 1; dt_vpn = t.vpn; dt_store = t.st; end
    else        begin if_req = 1; if_vpn = t.vpn; end
    for (int c = 0; c < 4; c++) begin
      #1;
      if (t.side) begin
        if (dt_ready)             begin got_code = 0; got_pfn = dt_pfn; end
        else if (dt_modify_fault) got_code = 2;
        else if (dt_refill_fault) got_code = 1;
        else if (dt_multi_err)    got_code = 3;
      end else begin
        if (if_ready)             begin got_code = 0; got_pfn = if_pfn; end
        else if (if_refill_fault) got_code = 1;
        else if (if_multi_err)    got_code = 3;
      end
      if (got_code >= 0) begin got_lat = c; break; end
      @(negedge clk);
    end
    check(got_code == int'(t.code) && got_lat == int'(t.lat) &&
          (t.code != 0 || got_pfn == t.pfn), int'(t.req),
          $sformatf("vpn %0h outcome/latency/pfn", t.vpn),
          {got_code[3:0], got_lat[3:0], 4'h0, got_pfn},
          {2'b0, t.code, 2'b0, t.lat, 4'h0, t.pfn});
    @(negedge clk);
    if_req = 0; dt_req = 0; dt_store = 0;
  endtask

  initial begin
    #(5ns * 100000);
    check(1'b0, 0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R12: outputs quiet in reset, even with requests raised
    if_req = 1; dt_req = 1; if_vpn = 20'h20; dt_vpn = 20'h20;
    repeat (3) @(negedge clk);
    #1;
    check(!if_ready && !dt_ready && !if_refill_fault && !dt_refill_fault &&
          !dt_modify_fault && !if_multi_err && !dt_multi_err, 12,
          "outputs in reset", 0, 0);
    if_req = 0; dt_req = 0;
    @(negedge clk); rst_n = 1;
    // R12: empty main array after reset
    access('{1'b0, 1'b0, 20'h20, 2'd1, 20'h0, 2'd1, 8'd12});
    access('{1'b1, 1'b0, 20'h20, 2'd1, 20'h0, 2'd1, 8'd12});

    // R1: program the main array
    wr_entry(4'd0, 19'h10, 20'h100, 20'h101, 2'b11, 2'b01);
    wr_entry(4'd1, 19'h11, 20'h200, 20'h201, 2'b01, 2'b11);
    wr_entry(4'd2, 19'h12, 20'h300, 20'h301, 2'b11, 2'b11);
    wr_entry(4'd3, 19'h13, 20'h400, 20'h401, 2'b11, 2'b11);
    wr_entry(4'd4, 19'h14, 20'h500, 20'h501, 2'b01, 2'b11);
    wr_entry(4'd5, 19'h14, 20'h510, 20'h511, 2'b01, 2'b11);

    for (int i = 0; i < NV; i++) access(VEC[i]);

    // R8: a write flushes the fetch micro-buffer (0x20 was a hit)
    wr_entry(4'd6, 19'h15, 20'h600, 20'h601, 2'b11, 2'b11);
    access('{1'b0, 1'b0, 20'h20, 2'd0, 20'h100, 2'd1, 8'd8});

    // R10: both sides miss together, data served first
    @(negedge clk);
    if_req = 1; if_vpn = 20'h2B; dt_req = 1; dt_vpn = 20'h2A;
    #1;
    check(!if_ready && !dt_ready, 10, "cycle0 both miss", {if_ready, dt_ready}, 0);
    @(negedge clk); #1;
    check(dt_ready && dt_pfn == 20'h600 && !if_ready, 10, "cycle1 data first",
          {if_ready, dt_ready, dt_pfn}, {2'b01, 20'h600});
    @(negedge clk); #1;
    check(if_ready && if_pfn == 20'h601, 10, "cycle2 fetch second",
          {if_ready, if_pfn}, {1'b1, 20'h601});
    @(negedge clk);
    if_req = 0; dt_req = 0;

    // R11: a write on the lookup cycle cancels the refill
    @(negedge clk);
    dt_req = 1; dt_vpn = 20'h26;
    wr_en = 1; wr_idx = 4'd7; wr_tag = 19'h3F; wr_valid = 2'b00; wr_writable = 2'b00;
    #1;
    check(!dt_ready, 11, "cycle0 no ready", dt_ready, 0);
    @(negedge clk);
    wr_en = 0;
    #1;
    check(!dt_ready && !dt_refill_fault && !dt_multi_err, 11, "cycle1 lookup dropped",
          {dt_ready, dt_refill_fault, dt_multi_err}, 0);
    @(negedge clk); #1;
    check(dt_ready && dt_pfn == 20'h400, 11, "cycle2 retried lookup",
          {dt_ready, dt_pfn}, {1'b1, 20'h400});
    @(negedge clk);
    dt_req = 0;

    // R12: reset mid-run empties everything
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    access('{1'b1, 1'b0, 20'h20, 2'd1, 20'h0, 2'd1, 8'd12});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule